// File: doc/BRIEF.md
# Batch-Then-Slack Priority Arbiter

This block picks one winner among the virtual channels of a mesh router that compete for the same output resource. It serves the virtual-channel allocation stage and the switch allocation stage. Each requester carries a batch number and a slack tag. A packet from an older batch always beats one from a younger batch. Within the same batch, the smaller slack tag wins. Requesters that are still tied are served in rotating order.

Time is cut into fixed intervals by an injection-side batch counter. Every packet injected during one interval takes that interval's number, so no packet can be passed over forever. Only a head flit presents its own batch and slack. When a head flit wins, its key is stored in a per-channel priority field. The body flits that follow compete with that stored key, and the field is released when the tail flit is granted.

Top module: `batch_slack_arb`

## Requirements
- R1: Reset clears every priority field, sets the batch counter to 0 and deasserts the grant. After reset, a body request (head bit 0) on a channel whose field is empty is never granted.
- R2: `curBatch` starts at 0, advances by exactly 1 after every BATCH_CYCLES clock edges out of reset, and wraps modulo 2^BATCH_W.
- R3: Batch age is `(curBatch - batch) mod 2^BATCH_W`. A requester with a larger age wins over any requester with a smaller age, whatever the slack tags.
- R4: Among eligible requesters of equal age, the one with the numerically smallest slack tag wins.
- R5: Among requesters with equal age and slack, the winner is the first one found at or after a rotating pointer. The pointer starts at index 0 after reset and moves to the winner's index plus 1, wrapping to 0, after every grant.
- R6: A head-flit request (head bit 1) competes with its own `reqBatch`/`reqSlack`. When a head wins and its tail bit is 0, its key is stored for that channel. Later body requests on that channel compete with the stored key and ignore their own batch and slack inputs.
- R7: When a request with tail bit 1 is granted, that channel's field is emptied. A later body request on it is not granted until a head flit reloads the field.
- R8: Age ordering holds across counter wraparound: with `curBatch` = 0, batch 7 is older than batch 0, and with `curBatch` = 1, batch 7 is older than batch 0, which is older than batch 1 (BATCH_W = 3).
- R9: The `grant` output is one-hot when `grantValid` is 1 and zero otherwise, and bit `grantIdx` is the one set.
- R10: No grant is issued to a requester whose `reqValid` bit is 0. With no valid requests, `grantValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_PORTS*NUM_VCS | Per-channel request |
| reqHead | input | NUM_PORTS*NUM_VCS | Request comes from a head flit |
| reqTail | input | NUM_PORTS*NUM_VCS | Request comes from a tail flit (a single-flit packet sets head and tail) |
| reqBatch | input | NUM_PORTS*NUM_VCS*BATCH_W | Batch number of each head flit; channel i uses bits [i*BATCH_W +: BATCH_W] |
| reqSlack | input | NUM_PORTS*NUM_VCS*SLACK_W | Slack tag of each head flit; channel i uses bits [i*SLACK_W +: SLACK_W] |
| grant | output | NUM_PORTS*NUM_VCS | One-hot grant |
| grantValid | output | 1 | A grant is issued this cycle |
| grantIdx | output | clog2(NUM_PORTS*NUM_VCS) | Index of the granted channel |
| curBatch | output | BATCH_W | Batch number for packets injected now |

## Verification
The assertions assume that the upstream logic holds each channel in wormhole order: a head, then body flits, then a tail. They also assume that no more than 2^BATCH_W batches are alive at once, so age modulo the counter width stays meaningful. The stimulus keeps to this. Every multi-flit sequence opens with a head and closes with a tail. The only out-of-order case is the deliberate body request on an emptied channel. All batch numbers used lie within the few intervals behind `curBatch`. The wrap cases are reached by letting the counter run through a full cycle of batch numbers.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  // strobes from control to datapath for the per-channel priority field
  typedef struct packed {
    logic loadEn;   // store the granted head's key
    logic clearEn;  // release the granted channel's field
  } bsaStrobe_t;
endpackage

// File: rtl/bsa_datapath.sv
module bsa_datapath
  import bsa_pkg::*;
#(
  parameter int NUM_REQ = 30,
  parameter int BATCH_W = 3,
  parameter int SLACK_W = 5,
  parameter int IDX_W   = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_REQ-1:0]         reqValid,
  input  logic [NUM_REQ-1:0]         reqHead,
  input  logic [NUM_REQ-1:0]         reqTail,
  input  logic [NUM_REQ*BATCH_W-1:0] reqBatch,
  input  logic [NUM_REQ*SLACK_W-1:0] reqSlack,
  input  logic [BATCH_W-1:0]         curBatch,
  input  logic [IDX_W-1:0]           rrPtr,
  input  bsaStrobe_t                 strobe,
  input  logic [IDX_W-1:0]           strobeIdx,
  output logic                       winValid,
  output logic [IDX_W-1:0]           winIdx,
  output logic                       winHead,
  output logic                       winTail
);
  localparam int KEY_W = BATCH_W + SLACK_W;

  logic [NUM_REQ-1:0] fieldValid;
  logic [BATCH_W-1:0] fieldBatch [NUM_REQ];
  logic [SLACK_W-1:0] fieldSlack [NUM_REQ];
  logic [KEY_W-1:0]   keyArr     [NUM_REQ];
  logic [NUM_REQ-1:0] eligible;
  logic [NUM_REQ-1:0] cand;
  logic [KEY_W-1:0]   minKey;

  // per-channel priority field, loaded by a winning head, cleared by a tail
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fieldValid <= '0;
      for (int i = 0; i < NUM_REQ; i++) begin
        fieldBatch[i] <= '0;
        fieldSlack[i] <= '0;
      end
    end else if (strobe.clearEn) begin
      fieldValid[strobeIdx] <= 1'b0;
    end else if (strobe.loadEn) begin
      fieldValid[strobeIdx] <= 1'b1;
      fieldBatch[strobeIdx] <= reqBatch[strobeIdx*BATCH_W +: BATCH_W];
      fieldSlack[strobeIdx] <= reqSlack[strobeIdx*SLACK_W +: SLACK_W];
    end
  end

  // comparison key per channel: inverted age on top, slack below; smaller wins
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_key
    logic [BATCH_W-1:0] effBatch;
    logic [SLACK_W-1:0] effSlack;
    logic [BATCH_W-1:0] age;
    always_comb begin
      effBatch    = reqHead[g] ? reqBatch[g*BATCH_W +: BATCH_W] : fieldBatch[g];
      effSlack    = reqHead[g] ? reqSlack[g*SLACK_W +: SLACK_W] : fieldSlack[g];
      age         = curBatch - effBatch;
      keyArr[g]   = {~age, effSlack};
      eligible[g] = reqValid[g] & (reqHead[g] | fieldValid[g]);
    end
  end

  always_comb begin
    minKey = '1;
    for (int i = 0; i < NUM_REQ; i++)
      if (eligible[i] && keyArr[i] < minKey) minKey = keyArr[i];
    for (int i = 0; i < NUM_REQ; i++)
      cand[i] = eligible[i] && (keyArr[i] == minKey);
  end

  // rotating pick among the best-key candidates
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    for (int k = 0; k < NUM_REQ; k++) begin
      int j;
      j = int'(rrPtr) + k;
      if (j >= NUM_REQ) j = j - NUM_REQ;
      if (!winValid && cand[j]) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(j);
      end
    end
    winHead = winValid & reqHead[winIdx];
    winTail = winValid & reqTail[winIdx];
  end
endmodule

// File: rtl/bsa_control.sv
module bsa_control
  import bsa_pkg::*;
#(
  parameter int NUM_REQ      = 30,
  parameter int BATCH_W      = 3,
  parameter int BATCH_CYCLES = 16,
  parameter int IDX_W        = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               winValid,
  input  logic [IDX_W-1:0]   winIdx,
  input  logic               winHead,
  input  logic               winTail,
  output bsaStrobe_t         strobe,
  output logic [IDX_W-1:0]   rrPtr,
  output logic [BATCH_W-1:0] curBatch
);
  localparam int CYC_W = (BATCH_CYCLES > 1) ? $clog2(BATCH_CYCLES) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(BATCH_CYCLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_REQ - 1);

  logic [CYC_W-1:0] cycleCnt;

  // injection-side batch interval counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleCnt <= '0;
      curBatch <= '0;
    end else if (cycleCnt == CYC_LAST) begin
      cycleCnt <= '0;
      curBatch <= curBatch + 1'b1;
    end else begin
      cycleCnt <= cycleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rrPtr <= '0;
    else if (winValid) rrPtr <= (winIdx == IDX_LAST) ? '0 : winIdx + 1'b1;
  end

  always_comb begin
    strobe.clearEn = winValid & winTail;
    strobe.loadEn  = winValid & winHead & ~winTail;
  end
endmodule

// File: rtl/batch_slack_arb.sv
module batch_slack_arb
  import bsa_pkg::*;
#(
  parameter int NUM_PORTS    = 5,
  parameter int NUM_VCS      = 6,
  parameter int BATCH_W      = 3,
  parameter int SLACK_W      = 5,
  parameter int BATCH_CYCLES = 16,
  localparam int NUM_REQ     = NUM_PORTS * NUM_VCS,
  localparam int IDX_W       = $clog2(NUM_REQ)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_REQ-1:0]         reqValid,
  input  logic [NUM_REQ-1:0]         reqHead,
  input  logic [NUM_REQ-1:0]         reqTail,
  input  logic [NUM_REQ*BATCH_W-1:0] reqBatch,
  input  logic [NUM_REQ*SLACK_W-1:0] reqSlack,
  output logic [NUM_REQ-1:0]         grant,
  output logic                       grantValid,
  output logic [IDX_W-1:0]           grantIdx,
  output logic [BATCH_W-1:0]         curBatch
);
  bsaStrobe_t       strobe;
  logic [IDX_W-1:0] rrPtr;
  logic             winValid, winHead, winTail;
  logic [IDX_W-1:0] winIdx;

  bsa_datapath #(
    .NUM_REQ(NUM_REQ), .BATCH_W(BATCH_W), .SLACK_W(SLACK_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqHead(reqHead),
    .reqTail(reqTail), .reqBatch(reqBatch), .reqSlack(reqSlack),
    .curBatch(curBatch), .rrPtr(rrPtr), .strobe(strobe), .strobeIdx(winIdx),
    .winValid(winValid), .winIdx(winIdx), .winHead(winHead), .winTail(winTail)
  );

  bsa_control #(
    .NUM_REQ(NUM_REQ), .BATCH_W(BATCH_W), .BATCH_CYCLES(BATCH_CYCLES), .IDX_W(IDX_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .winValid(winValid), .winIdx(winIdx),
    .winHead(winHead), .winTail(winTail), .strobe(strobe), .rrPtr(rrPtr),
    .curBatch(curBatch)
  );

  assign grantValid = winValid;
  assign grantIdx   = winIdx;
  assign grant      = winValid ? (NUM_REQ'(1) << winIdx) : '0;
endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
  parameter int NUM_REQ = 30,
  parameter int BATCH_W = 3,
  parameter int IDX_W   = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_REQ-1:0] reqValid,
  input logic [NUM_REQ-1:0] reqHead,
  input logic [NUM_REQ-1:0] reqTail,
  input logic [NUM_REQ-1:0] grant,
  input logic               grantValid,
  input logic [IDX_W-1:0]   grantIdx,
  input logic [BATCH_W-1:0] curBatch
);
  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R9
  grant_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> grant[grantIdx]);

  // R10
  grant_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~reqValid) == '0);

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid == '0) |-> !grantValid);

  // R2
  batch_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curBatch) |-> curBatch == BATCH_W'($past(curBatch) + 1'b1));

  // R7
  tail_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && reqTail[grantIdx]) |=>
      !(grant[$past(grantIdx)] && !reqHead[$past(grantIdx)]));
endmodule

bind batch_slack_arb bsa_checker #(
  .NUM_REQ(NUM_REQ), .BATCH_W(BATCH_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqHead(reqHead),
  .reqTail(reqTail), .grant(grant), .grantValid(grantValid),
  .grantIdx(grantIdx), .curBatch(curBatch)
);

// File: tb/batch_slack_arb_tb.sv
`timescale 1ns/1ps
module batch_slack_arb_tb;
  localparam int N  = 30;
  localparam int BW = 3;
  localparam int SW = 5;
  localparam int BC = 16;
  localparam int IW = $clog2(N);

  logic clk = 0;
  logic rstN = 0;
  logic [N-1:0]    reqValid = '0, reqHead = '0, reqTail = '0;
  logic [N*BW-1:0] reqBatch = '0;
  logic [N*SW-1:0] reqSlack = '0;
  logic [N-1:0]    grant;
  logic            grantValid;
  logic [IW-1:0]   grantIdx;
  logic [BW-1:0]   curBatch;

  batch_slack_arb u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqHead(reqHead),
    .reqTail(reqTail), .reqBatch(reqBatch), .reqSlack(reqSlack),
    .grant(grant), .grantValid(grantValid), .grantIdx(grantIdx),
    .curBatch(curBatch)
  );

  always #2 clk = ~clk;

  int testsRun = 0, testsFail = 0;
  int cycles = 0;
  always @(posedge clk) if (rstN) cycles <= cycles + 1;

  // pending stimulus for the next step
  bit pV[N], pH[N], pT[N];
  int pB[N], pS[N];
  // reference state
  bit mValid[N];
  int mB[N], mS[N];
  int rr = 0;

  typedef struct { int idx; int batch; string tag; } expItem_t;
  expItem_t sb[$];
  event sampleEv;

  // monitor: pops one expected item per step and compares
  initial forever begin
    @(sampleEv);
    while (sb.size() > 0) begin
      expItem_t e;
      e = sb.pop_front();
      testsRun++;
      if (e.idx < 0) begin
        if (grantValid !== 1'b0 || grant !== '0) begin
          testsFail++;
          $display("FAIL %s: grantValid=%0b grant=%h expected no grant", e.tag, grantValid, grant);
        end
      end else if (grantValid !== 1'b1 || grantIdx !== IW'(e.idx) ||
                   grant !== (N'(1) << e.idx)) begin
        testsFail++;
        $display("FAIL %s: grantValid=%0b idx=%0d grant=%h expected idx=%0d", e.tag,
                 grantValid, grantIdx, grant, e.idx);
      end
      testsRun++;
      if (curBatch !== BW'(e.batch)) begin
        testsFail++;
        $display("FAIL R2: curBatch=%0d expected %0d", curBatch, e.batch);
      end
    end
  end

  task automatic clearPend();
    for (int i = 0; i < N; i++) begin
      pV[i] = 0; pH[i] = 0; pT[i] = 0; pB[i] = 0; pS[i] = 0;
    end
  endtask

  task automatic setReq(int i, bit h, bit t, int b, int s);
    pV[i] = 1; pH[i] = h; pT[i] = t; pB[i] = b; pS[i] = s;
  endtask

  task automatic step(string tag);
    int cur, minKey, win;
    int key[N];
    bit elig[N];
    expItem_t e;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      reqValid[i] = pV[i]; reqHead[i] = pH[i]; reqTail[i] = pT[i];
      reqBatch[i*BW +: BW] = BW'(pB[i]);
      reqSlack[i*SW +: SW] = SW'(pS[i]);
    end
    #1;
    cur = (cycles / BC) % 8;
    minKey = 1 << 30;
    for (int i = 0; i < N; i++) begin
      int eb, es;
      elig[i] = pV[i] && (pH[i] || mValid[i]);
      eb = pH[i] ? pB[i] : mB[i];
      es = pH[i] ? pS[i] : mS[i];
      key[i] = ((7 - ((cur - eb) & 7)) << 5) + es;
      if (elig[i] && key[i] < minKey) minKey = key[i];
    end
    win = -1;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (rr + k) % N;
      if (win < 0 && elig[j] && key[j] == minKey) win = j;
    end
    e.idx = win; e.batch = cur; e.tag = tag;
    sb.push_back(e);
    ->sampleEv;
    if (win >= 0) begin
      rr = (win + 1) % N;
      if (pT[win]) mValid[win] = 0;
      else if (pH[win]) begin mValid[win] = 1; mB[win] = pB[win]; mS[win] = pS[win]; end
    end
    clearPend();
  endtask

  initial begin
    #(4.0 * 200000);
    testsFail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mValid[i] = 0;
    clearPend();
    repeat (3) @(posedge clk);
    @(negedge clk);
    testsRun++;
    if (grantValid !== 1'b0 || curBatch !== '0) begin
      testsFail++;
      $display("FAIL R1: grantValid=%0b curBatch=%0d expected 0 0", grantValid, curBatch);
    end
    rstN = 1;

    // R1: body on an empty field is not granted
    setReq(0, 0, 0, 3, 3); step("R1");
    // R10: nothing requested
    step("R10");
    // R3: older batch (7 at curBatch 0) beats lower slack
    setReq(3, 1, 1, 7, 31); setReq(10, 1, 1, 0, 0); step("R3");
    // R4: same batch, smaller slack wins
    setReq(5, 1, 1, 0, 9); setReq(20, 1, 1, 0, 4); step("R4");
    // R5: equal keys rotate
    for (int r = 0; r < 4; r++) begin
      setReq(2, 1, 1, 0, 6); setReq(7, 1, 1, 0, 6); setReq(12, 1, 1, 0, 6);
      step("R5");
    end
    // R6: head loads field, body uses it despite its own inputs
    setReq(4, 1, 0, 0, 1); step("R6");
    setReq(4, 0, 0, 0, 31); setReq(9, 1, 1, 0, 2); step("R6");
    // R7: tail releases, then body alone not granted
    setReq(4, 0, 1, 5, 31); step("R7");
    setReq(4, 0, 0, 0, 0); step("R7");
    // R2: run into batch 1
    while (cycles < BC + 2) step("R2");
    // R8: at curBatch 1, batch 7 oldest, then 0, then 1
    setReq(1, 1, 1, 1, 0); setReq(8, 1, 1, 0, 30); setReq(15, 1, 1, 7, 31); step("R8");
    setReq(1, 1, 1, 1, 0); setReq(8, 1, 1, 0, 30); step("R8");
    // R2: let the counter wrap back to 0
    while (cycles < 8 * BC + 2) step("R2");
    // R8: after wrap, batch 7 older than batch 0
    setReq(22, 1, 1, 0, 0); setReq(29, 1, 1, 7, 20); step("R8");
    @(negedge clk);
    #1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end
endmodule